// File: doc/BRIEF.md
# Nine-Bit Address-Filtering UART

This block is a serial transmitter and receiver pair that moves nine-bit characters: eight data bits plus a ninth bit. On a shared multi-drop line the ninth bit separates station addresses (ninth bit one) from payload (ninth bit zero). The ninth bit is sent last, after the eight data bits, which go out least significant bit first. Each character is framed by one start bit and one or two stop bits. Bit timing comes from an external tick that runs at sixteen times the bit rate.

The receiver has an attention filter. While the attention flag is set, characters with the ninth bit clear are dropped without a trace. The first character with the ninth bit set is delivered, and the flag clears itself so that the following payload gets through. Software can set the flag again to skip payload until the next address. The transmitter is not affected by the flag.

For diagnostics, a loopback setting feeds the transmit shift output straight into the receiver and holds the external transmit pin idle, so that a written character comes back through the receive buffer.

Top module: `uart9_addr_filter`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `tx_busy` is 0, `rx_full` is 0, both error flags are 0 and `attn_on` is 0.
- R2: A transmitted frame on `txd` is a 0 start bit, then `tx_data` bit 0 to bit 7, then `tx_bit9`, then stop bits at 1. Each bit lasts 16 `baud_tick` periods.
- R3: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two. With back-to-back characters, start edges are 11 or 12 bit times apart.
- R4: A received frame with its ninth bit on `rx_bit9` and its data on `rx_data` sets `rx_full`. A pulse on `rx_rd` clears `rx_full`.
- R5: A low pulse on the receive line that is shorter than half a bit time is not taken as a start bit, and no character results.
- R6: A low line at the stop-bit sample sets `rx_frame_err`. The character is still delivered.
- R7: An accepted character that completes while `rx_full` is 1 sets `rx_overrun` and leaves `rx_data` and `rx_bit9` unchanged.
- R8: A pulse on `err_clr` clears both error flags and leaves `rx_data` and `rx_bit9` unchanged.
- R9: While `attn_on` is 1, a character whose ninth bit is 0 is dropped. It sets neither `rx_full` nor any error flag, and it does not change `rx_data`.
- R10: While `attn_on` is 1, a character whose ninth bit is 1 is delivered and clears `attn_on`. Later characters whose ninth bit is 0 are then delivered.
- R11: A pulse on `attn_set` sets `attn_on` again, so that data characters are skipped until the next address.
- R12: With `char_len` = 2'b11 (loopback), the transmit shift output drives the receiver, the `rxd` pin is ignored and `txd` stays at 1. Every other `char_len` value uses the pins.
- R13: `tx_wr` fills the transmit buffer (`tx_empty` goes to 0). The buffer empties when the shifter takes the character, and attention mode has no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| char_len | input | 2 | Length setting; 2'b11 selects loopback |
| two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| attn_set | input | 1 | Pulse that sets the attention flag |
| tx_wr | input | 1 | Pulse that writes the transmit buffer |
| tx_data | input | 8 | Transmit data byte |
| tx_bit9 | input | 1 | Ninth bit to send with the byte |
| tx_empty | output | 1 | Transmit buffer can accept a character |
| tx_busy | output | 1 | A frame is being shifted out |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_rd | input | 1 | Pulse that releases the receive buffer |
| err_clr | input | 1 | Pulse that clears the error flags |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_frame_err | output | 1 | Sticky framing error |
| rx_overrun | output | 1 | Sticky overrun error |
| attn_on | output | 1 | Attention filter active |

## Verification
The assertions check every cycle that a dropped character leaves the buffer alone, that an accepted address clears the attention flag, that an overrun keeps the stored character, that clearing the errors works, and that the transmit buffer and start bit behave correctly when a character is loaded. Only the bench scenarios can show the serial side: bit order and bit width on the line, the frame spacing for one or two stop bits, rejection of a short glitch, framing errors caused by a low stop bit, and a character looping back through the receiver while the pin stays high. A behavioural model of the receive buffer state is compared against the outputs on every clock outside the frames.

// File: rtl/nbu_pkg.sv
package nbu_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // start + word + stop bits
  function automatic int unsigned frame_len(input int unsigned word_w, input logic two_stop);
    return 1 + word_w + (two_stop ? 2 : 1);
  endfunction

  // tick count at which the start-bit midpoint is checked
  function automatic int unsigned mid_count(input int unsigned ovs);
    return (ovs / 2) - 1;
  endfunction

  // only the all-ones length setting routes the shifter back inward
  function automatic logic loop_sel(input logic [1:0] len);
    return len == 2'b11;
  endfunction

endpackage

// File: rtl/nbu_tx.sv
module nbu_tx
  import nbu_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit9,
  input  logic              two_stop,
  output logic              ser_o,
  output logic              buf_empty_o,
  output logic              busy_o,
  output logic              load_o
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned SH_W   = WORD_W + 3;
  localparam int unsigned CNT_W  = $clog2(OVS);
  localparam int unsigned LEFT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [WORD_W-1:0] buf_q;
  logic              buf_full_q;
  logic [SH_W-1:0]   sh_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEFT_W-1:0] left_q;
  logic              bit_end;
  logic              finish;

  assign bit_end = busy_q && tick && (cnt_q == LAST);
  assign finish  = bit_end && (left_q == '0);
  // a waiting character is taken on the same tick the last stop bit ends
  assign load_o  = tick && buf_full_q && (!busy_q || finish);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
    end else if (wr) begin
      buf_q      <= {wbit9, wdata};
      buf_full_q <= 1'b1;
    end else if (load_o) begin
      buf_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (load_o) begin
      sh_q   <= {2'b11, buf_q, 1'b0};
      busy_q <= 1'b1;
      cnt_q  <= '0;
      left_q <= LEFT_W'(frame_len(WORD_W, two_stop) - 1);
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (finish) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[SH_W-1:1]};
          left_q <= left_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ser_o       = busy_q ? sh_q[0] : 1'b1;
  assign buf_empty_o = !buf_full_q;
  assign busy_o      = busy_q;

endmodule

// File: rtl/nbu_rx.sv
module nbu_rx
  import nbu_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  output logic            done_o,
  output logic [DATA_W:0] word_o,
  output logic            stop_bad_o
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(OVS);
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] MID   = CNT_W'(mid_count(OVS));
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP_I = IDX_W'(WORD_W - 1);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              mid_pt;
  logic              bit_end;

  assign mid_pt  = tick && (cnt_q == MID);
  assign bit_end = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      done_o     <= 1'b0;
      word_o     <= '0;
      stop_bad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (tick && !rxd) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: begin
          if (mid_pt) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= rxd ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {rxd, sh_q[WORD_W-1:1]};
            if (idx_q == TOP_I) st_q <= RX_STOP;
            else                idx_q <= idx_q + 1'b1;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_q      <= '0;
            st_q       <= RX_IDLE;
            done_o     <= 1'b1;
            word_o     <= sh_q;
            stop_bad_o <= !rxd;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nbu_rxbuf.sv
module nbu_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W:0]   word_i,
  input  logic              stop_bad_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  input  logic              attn_set_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              ov_o,
  output logic              attn_o,
  output logic              accept_o,
  output logic              drop_o
);
  logic is_addr;

  assign is_addr  = word_i[DATA_W];
  assign drop_o   = done_i && attn_o && !is_addr;
  assign accept_o = done_i && !drop_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      full_o <= 1'b0;
    end else if (accept_o) begin
      full_o <= 1'b1;
      if (!full_o) begin
        data_o <= word_i[DATA_W-1:0];
        bit9_o <= is_addr;
      end
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_o <= 1'b0;
      ov_o <= 1'b0;
    end else begin
      fe_o <= (accept_o && stop_bad_i) || (fe_o && !err_clr_i);
      ov_o <= (accept_o && full_o)     || (ov_o && !err_clr_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   attn_o <= 1'b0;
    else if (attn_set_i)          attn_o <= 1'b1;
    else if (accept_o && is_addr) attn_o <= 1'b0;
  end

endmodule

// File: rtl/uart9_addr_filter.sv
module uart9_addr_filter
  import nbu_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        char_len,
  input  logic              two_stop,
  input  logic              attn_set,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  output logic              tx_empty,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_rd,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_full,
  output logic              rx_frame_err,
  output logic              rx_overrun,
  output logic              attn_on
);
  localparam int unsigned SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic              loop_on;
  logic              tx_ser;
  logic              tx_load;
  logic              rx_src;
  logic [SYNC_N-1:0] sync_q;
  logic              rx_done;
  logic [DATA_W:0]   rx_word;
  logic              rx_stop_bad;
  logic              rx_accept;
  logic              rx_drop;

  assign loop_on = loop_sel(char_len);

  nbu_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .wr         (tx_wr),
    .wdata      (tx_data),
    .wbit9      (tx_bit9),
    .two_stop   (two_stop),
    .ser_o      (tx_ser),
    .buf_empty_o(tx_empty),
    .busy_o     (tx_busy),
    .load_o     (tx_load)
  );

  assign txd    = loop_on ? 1'b1 : tx_ser;
  assign rx_src = loop_on ? tx_ser : rxd;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rx_src};
  end

  nbu_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .rxd       (sync_q[SYNC_N-1]),
    .done_o    (rx_done),
    .word_o    (rx_word),
    .stop_bad_o(rx_stop_bad)
  );

  nbu_rxbuf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (rx_done),
    .word_i    (rx_word),
    .stop_bad_i(rx_stop_bad),
    .rd_i      (rx_rd),
    .err_clr_i (err_clr),
    .attn_set_i(attn_set),
    .data_o    (rx_data),
    .bit9_o    (rx_bit9),
    .full_o    (rx_full),
    .fe_o      (rx_frame_err),
    .ov_o      (rx_overrun),
    .attn_o    (attn_on),
    .accept_o  (rx_accept),
    .drop_o    (rx_drop)
  );

endmodule

// File: rtl/nbu_checker.sv
module nbu_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              attn_set,
  input logic              err_clr,
  input logic              rx_rd,
  input logic              tx_wr,
  input logic              tx_empty,
  input logic              txd,
  input logic              loop_on,
  input logic              tx_load,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_full,
  input logic              rx_frame_err,
  input logic              rx_overrun,
  input logic              attn_on,
  input logic              rx_accept,
  input logic              rx_drop
);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !loop_on) |=> !txd);

  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && rx_full) |=> (rx_overrun && $stable(rx_data) && $stable(rx_bit9)));

  a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_accept) |=> (!rx_frame_err && !rx_overrun));

  a_r9_drop_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_rd) |=> ($stable(rx_full) && $stable(rx_data) && $stable(rx_bit9)));

  a_r9_drop_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_frame_err && !rx_overrun) |=> (!rx_frame_err && !rx_overrun));

  a_r10_addr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && attn_on && !attn_set) |=> !attn_on);

  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> rx_full);

  a_r13_wr_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  a_r13_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_wr) |=> tx_empty);

endmodule

bind uart9_addr_filter nbu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .attn_set    (attn_set),
  .err_clr     (err_clr),
  .rx_rd       (rx_rd),
  .tx_wr       (tx_wr),
  .tx_empty    (tx_empty),
  .txd         (txd),
  .loop_on     (loop_on),
  .tx_load     (tx_load),
  .rx_data     (rx_data),
  .rx_bit9     (rx_bit9),
  .rx_full     (rx_full),
  .rx_frame_err(rx_frame_err),
  .rx_overrun  (rx_overrun),
  .attn_on     (attn_on),
  .rx_accept   (rx_accept),
  .rx_drop     (rx_drop)
);

// File: tb/sim_uart9_addr_filter.sv
`timescale 1ns/1ps
module sim_uart9_addr_filter;
  localparam int BIT_CLK = 64;   // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tcnt = 2'd0;
  logic       baud_tick;
  logic [1:0] char_len = 2'b10;
  logic       two_stop = 1'b0;
  logic       attn_set = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_bit9 = 1'b0;
  logic       tx_empty, tx_busy, txd;
  logic       rxd_drv = 1'b1;
  logic       rx_rd = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_full, rx_frame_err, rx_overrun, attn_on;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // reference state of the receive side
  bit       m_full = 0, m_fe = 0, m_ov = 0, m_attn = 0, m_b9 = 0;
  bit [7:0] m_data = 8'h00;

  logic [8:0] got_q[$];
  int         got_t[$];
  bit         got_ok[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= tcnt + 2'd1;
    cyc  <= cyc + 1;
  end
  assign baud_tick = (tcnt == 2'd3);

  uart9_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_len(char_len),
    .two_stop(two_stop), .attn_set(attn_set), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_bit9(tx_bit9), .tx_empty(tx_empty), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd_drv), .rx_rd(rx_rd), .err_clr(err_clr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_full(rx_full), .rx_frame_err(rx_frame_err),
    .rx_overrun(rx_overrun), .attn_on(attn_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference (R4 R6 R7 R8 R9 R10 R11 R12)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      n_cmp++;
      if ({rx_full, rx_data, rx_bit9, rx_frame_err, rx_overrun, attn_on} !==
          {m_full, m_data, m_b9, m_fe, m_ov, m_attn}) begin
        n_bad++;
        if (n_bad < 20)
          $display("FAIL R4/R9 per-clock state: actual %h expected %h",
                   {rx_full, rx_data, rx_bit9, rx_frame_err, rx_overrun, attn_on},
                   {m_full, m_data, m_b9, m_fe, m_ov, m_attn});
      end
    end
  end

  // serial monitor on txd
  initial begin : tx_mon
    logic [8:0] w;
    bit ok;
    int t0;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        t0 = cyc; ok = 1; w = '0;
        repeat (BIT_CLK/2) @(negedge clk);
        if (txd !== 1'b0) ok = 0;
        for (int k = 0; k < 9; k++) begin
          repeat (BIT_CLK) @(negedge clk);
          w[k] = txd;
        end
        repeat (BIT_CLK) @(negedge clk);
        if (txd !== 1'b1) ok = 0;
        got_q.push_back(w); got_t.push_back(t0); got_ok.push_back(ok);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model: delivery rule written from the requirements
  task automatic model_rx(input logic [8:0] w, input bit stop_ok);
    if (m_attn && !w[8]) return;
    if (m_full) m_ov = 1;
    else begin m_data = w[7:0]; m_b9 = w[8]; end
    m_full = 1;
    if (!stop_ok) m_fe = 1;
    if (w[8]) m_attn = 0;
  endtask

  task automatic rx_frame(input logic [8:0] w, input bit stop_ok);
    cmp_on = 0;
    rxd_drv = 1'b0; wait_clk(BIT_CLK);
    for (int k = 0; k < 9; k++) begin rxd_drv = w[k]; wait_clk(BIT_CLK); end
    if (stop_ok) begin rxd_drv = 1'b1; wait_clk(BIT_CLK); end
    else begin rxd_drv = 1'b0; wait_clk(48); rxd_drv = 1'b1; wait_clk(16); end
    wait_clk(80);
    model_rx(w, stop_ok);
    wait_clk(1);
    cmp_on = 1;
  endtask

  task automatic do_rd();
    cmp_on = 0; rx_rd = 1; wait_clk(1); rx_rd = 0; m_full = 0; wait_clk(1); cmp_on = 1;
  endtask

  task automatic do_errclr();
    cmp_on = 0; err_clr = 1; wait_clk(1); err_clr = 0; m_fe = 0; m_ov = 0; wait_clk(1); cmp_on = 1;
  endtask

  task automatic do_attn();
    cmp_on = 0; attn_set = 1; wait_clk(1); attn_set = 0; m_attn = 1; wait_clk(1); cmp_on = 1;
  endtask

  task automatic tx_send(input logic [8:0] w);
    tx_data = w[7:0]; tx_bit9 = w[8]; tx_wr = 1; wait_clk(1); tx_wr = 0;
  endtask

  initial begin : main
    bit hi_all;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 errors", {rx_frame_err, rx_overrun}, 0);
    chk("R1 attn_on", attn_on, 0);
    cmp_on = 1;

    // attention on during transmit tests (R13: no effect on tx)
    do_attn();
    chk("R11 attn_on set", attn_on, 1);

    // R2 single frame, one stop
    got_q.delete(); got_t.delete(); got_ok.delete();
    two_stop = 0;
    tx_send(9'h1A5);
    wait_clk(900);
    chk("R2 frame count", got_q.size(), 1);
    if (got_q.size() >= 1) begin
      chk("R2 word on line", got_q[0], 9'h1A5);
      chk("R2 start/stop levels", got_ok[0], 1);
    end

    // R3 two stop bits back to back
    got_q.delete(); got_t.delete(); got_ok.delete();
    two_stop = 1;
    tx_send(9'h03C);
    while (tx_empty !== 1'b1) wait_clk(1);
    tx_send(9'h1C3);
    chk("R13 buffer held while busy", tx_empty, 0);
    wait_clk(1800);
    chk("R3 two-stop count", got_q.size(), 2);
    if (got_q.size() >= 2) begin
      chk("R3 two-stop spacing", got_t[1] - got_t[0], 12 * BIT_CLK);
      chk("R13 first word", got_q[0], 9'h03C);
      chk("R13 second word", got_q[1], 9'h1C3);
    end

    // R3 one stop bit back to back
    got_q.delete(); got_t.delete(); got_ok.delete();
    two_stop = 0;
    tx_send(9'h055);
    while (tx_empty !== 1'b1) wait_clk(1);
    tx_send(9'h0AA);
    wait_clk(1700);
    chk("R3 one-stop count", got_q.size(), 2);
    if (got_q.size() >= 2) begin
      chk("R3 one-stop spacing", got_t[1] - got_t[0], 11 * BIT_CLK);
      chk("R2 second word", got_q[1], 9'h0AA);
    end

    // R9 data dropped under attention, even with a bad stop
    rx_frame(9'h033, 1);
    chk("R9 data ignored", rx_full, 0);
    rx_frame(9'h0F0, 0);
    chk("R9 no framing error on dropped", rx_frame_err, 0);

    // R10 address accepted, attention cleared
    rx_frame(9'h15C, 1);
    chk("R10 address full", rx_full, 1);
    chk("R10 attention cleared", attn_on, 0);
    chk("R4 data and bit9", {rx_bit9, rx_data}, 9'h15C);
    do_rd();
    chk("R4 read clears full", rx_full, 0);

    // R10 following data delivered; R7 overrun
    rx_frame(9'h0C3, 1);
    chk("R10 data after address", {rx_full, rx_bit9, rx_data}, {1'b1, 9'h0C3});
    rx_frame(9'h011, 1);
    chk("R7 overrun set", rx_overrun, 1);
    chk("R7 data kept", rx_data, 8'hC3);
    do_errclr();
    chk("R8 overrun cleared", rx_overrun, 0);
    chk("R8 bit9 unchanged", {rx_bit9, rx_data}, 9'h0C3);
    do_rd();

    // R5 short glitch
    rxd_drv = 1'b0; wait_clk(16); rxd_drv = 1'b1; wait_clk(120);
    chk("R5 glitch ignored", rx_full, 0);

    // R6 framing error, still delivered
    rx_frame(9'h17E, 0);
    chk("R6 framing error", rx_frame_err, 1);
    chk("R6 delivered", {rx_full, rx_bit9, rx_data}, {1'b1, 9'h17E});
    do_errclr();
    chk("R8 framing cleared", rx_frame_err, 0);
    do_rd();

    // R11 re-arm attention
    do_attn();
    rx_frame(9'h044, 1);
    chk("R11 data skipped", rx_full, 0);
    rx_frame(9'h121, 1);
    chk("R11 next address", {rx_full, attn_on, rx_bit9, rx_data}, {2'b10, 9'h121});
    do_rd();

    // R12 loopback: pin held low and ignored, txd stays high
    cmp_on = 0;
    char_len = 2'b11;
    wait_clk(1);
    rxd_drv = 1'b0;
    tx_send(9'h096);
    hi_all = 1;
    for (int k = 0; k < 900; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) hi_all = 0;
    end
    chk("R12 txd held high", hi_all, 1);
    model_rx(9'h096, 1);
    chk("R12 looped word", {rx_full, rx_bit9, rx_data}, {1'b1, 9'h096});
    chk("R12 no framing error", rx_frame_err, 0);
    rxd_drv = 1'b1;
    wait_clk(10);
    char_len = 2'b10;
    wait_clk(2);
    cmp_on = 1;
    do_rd();
    wait_clk(20);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule